// File: doc/BRIEF.md
# Split-Byte Twin PWM Control DAC

This block turns a 16-bit control setpoint into two pulse-width-modulated logic outputs. The setpoint's upper byte sets the duty of one 8-bit modulator and its lower byte sets the duty of the other. Both modulators share one 256-step counter and therefore one carrier period. Off-chip, the two outputs are averaged through resistors weighted 256:1 and a capacitor, which gives a DC level with 16-bit resolution. Each modulator only has to reach 8-bit timing resolution, where a single 16-bit modulator would need 65536 steps per period.

A clock divider, set from the system clock frequency and the carrier frequency (96 kHz by default), produces the step tick. The setpoint is a plain level input. It is sampled only at a period boundary, so a period already in progress is never cut short or stretched. A force-high input drives both outputs high from the next clock edge, which pulls the external amplifier's output to zero. When force-high is removed, both outputs stay high until the next period boundary and then resume normal modulation. The setpoint and force-high are plain level pins with no handshake: the block takes the setpoint as it stands at each boundary and never stalls its source.

Top module: `pwm_pair_dac`

## Requirements
- R1: While reset is asserted and for the whole first period after reset is released, both outputs are low, whatever the setpoint is. Reset clears the step counter and the held duties to 0.
- R2: A period is 256 steps. Each step lasts DIV clocks, where DIV = CLK_HZ / (CARRIER_HZ * 256), with a minimum of 1.
- R3: In every period, `pwm_hi_o` is high for setpoint[15:8] * DIV clocks.
- R4: In every period, `pwm_lo_o` is high for setpoint[7:0] * DIV clocks. This output carries the 1/256 weight.
- R5: A duty of 0 keeps an output low for the whole period. A duty of 255 keeps it high for 255 of the 256 steps.
- R6: The setpoint is taken only at a period boundary. A setpoint change in the middle of a period has no effect until the next period.
- R7: Each output is high from the start of its period. It goes low once the step count reaches the held duty.
- R8: With `force_high` at 1, both outputs are high from the clock edge after it is sampled, and they remain high while it stays at 1.
- R9: After `force_high` returns to 0, both outputs stay high until the next period boundary. From that boundary they follow the held duties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| setpoint | input | 16 | Control word; the upper byte drives pwm_hi_o and the lower byte drives pwm_lo_o |
| force_high | input | 1 | Holds both outputs high |
| pwm_hi_o | output | 1 | Modulator output for the upper byte (high weight) |
| pwm_lo_o | output | 1 | Modulator output for the lower byte (1/256 weight) |

## Verification
The counter's phase cannot be seen at the ports, so the hardest cases to reach are those tied to the period boundary: a setpoint change in the middle of a period, and a release of force-high that must wait for the boundary. The stimulus recovers the phase by loading an upper duty of 1, so that `pwm_hi_o` gives one short pulse at the start of every period, and waiting for that rising edge. The mid-period change and the force-high release are then applied at a known offset from the boundary, so the expected high counts are exact. Steady duties are measured over any window one period long after enough time for the setpoint to be taken, which removes the need to know the phase at all.

// File: rtl/pwm_pair_dac_pkg.sv
package pwm_pair_dac_pkg;

  // Counter width of each modulator; a period has 2**STEP_W steps.
  localparam int STEP_W = 8;
  // Number of modulators fed from one setpoint.
  localparam int N_MOD  = 2;

  typedef logic [STEP_W-1:0] duty_t;

  // Clocks per step, never below one.
  function automatic int clocks_per_step(input longint clk_hz, input longint carrier_hz);
    longint q;
    q = clk_hz / (carrier_hz * (longint'(1) << STEP_W));
    if (q < 1) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/pwm_step_tick.sv
module pwm_step_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pwm_step_ctr.sv
module pwm_step_ctr
  import pwm_pair_dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_i,
  output duty_t cnt_o,
  output logic  wrap_o
);
  duty_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // Final step ends on this edge; next edge starts a new period.
  assign wrap_o = tick_i && (cnt_q == '1);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pwm_mod_slice.sv
module pwm_mod_slice
  import pwm_pair_dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wrap_i,
  input  duty_t cnt_i,
  input  duty_t duty_i,
  input  logic  hold_hi_i,
  output duty_t duty_q_o,
  output logic  pwm_o
);
  duty_t duty_q;

  // Duty is taken only at the period boundary, so a period is never cut.
  always_ff @(posedge clk) begin
    if (!rst_n)      duty_q <= '0;
    else if (wrap_i) duty_q <= duty_i;
  end

  assign duty_q_o = duty_q;
  assign pwm_o    = hold_hi_i | (cnt_i < duty_q);
endmodule

// File: rtl/pwm_pair_dac.sv
module pwm_pair_dac
  import pwm_pair_dac_pkg::*;
#(
  parameter longint CLK_HZ     = 98_304_000,
  parameter longint CARRIER_HZ = 96_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_MOD*STEP_W-1:0]  setpoint,
  input  logic                     force_high,
  output logic                     pwm_hi_o,
  output logic                     pwm_lo_o
);
  localparam int DIV = clocks_per_step(CLK_HZ, CARRIER_HZ);

  logic  tick;
  logic  wrap;
  duty_t step_cnt;
  logic  hold_q;
  duty_t duty_lat [N_MOD];
  logic  pwm_v    [N_MOD];

  pwm_step_tick #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pwm_step_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .cnt_o  (step_cnt),
    .wrap_o (wrap)
  );

  // Override: set on the next edge, cleared only at a boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)          hold_q <= 1'b0;
    else if (force_high) hold_q <= 1'b1;
    else if (wrap)       hold_q <= 1'b0;
  end

  // Slice i takes setpoint byte i; slice 1 is the high-weight byte.
  generate
    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
      pwm_mod_slice u_slice (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap),
        .cnt_i     (step_cnt),
        .duty_i    (setpoint[i*STEP_W +: STEP_W]),
        .hold_hi_i (hold_q),
        .duty_q_o  (duty_lat[i]),
        .pwm_o     (pwm_v[i])
      );
    end
  endgenerate

  assign pwm_hi_o = pwm_v[1];
  assign pwm_lo_o = pwm_v[0];
endmodule

// File: rtl/pwm_pair_dac_chk.sv
module pwm_pair_dac_chk
  import pwm_pair_dac_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  force_high,
  input logic  pwm_hi,
  input logic  pwm_lo,
  input logic  tick,
  input logic  wrap,
  input duty_t cnt,
  input duty_t duty_hi,
  input duty_t duty_lo,
  input logic  hold
);
  // R8
  force_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_high |=> (pwm_hi && pwm_lo));

  // R6
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(duty_hi) && $stable(duty_lo)));

  // R9
  release_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(wrap));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

  // R2
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R5
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_lo == '0 && !hold) |-> !pwm_lo);
endmodule

bind pwm_pair_dac pwm_pair_dac_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .force_high (force_high),
  .pwm_hi     (pwm_hi_o),
  .pwm_lo     (pwm_lo_o),
  .tick       (tick),
  .wrap       (wrap),
  .cnt        (step_cnt),
  .duty_hi    (duty_lat[1]),
  .duty_lo    (duty_lat[0]),
  .hold       (hold_q)
);

// File: tb/sim_pwm_pair_dac.sv
`timescale 1ns/1ps
module sim_pwm_pair_dac;
  localparam longint CLK_HZ = 73_728_000;
  localparam longint CAR_HZ = 96_000;
  localparam int D   = 3;        // clocks per step from R2 for these values
  localparam int PER = 256 * D;  // clocks per period

  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'hFFFF, 16'h0100, 16'h00FF,
    16'h8001, 16'h12AB, 16'hFE02, 16'h7F80
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] setpoint = 16'h0000;
  logic force_high = 1'b0;
  logic pwm_hi_o, pwm_lo_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_pair_dac #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .setpoint(setpoint),
    .force_high(force_high), .pwm_hi_o(pwm_hi_o), .pwm_lo_o(pwm_lo_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_hi(input int n, output int h1, output int h2);
    h1 = 0; h2 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      h1 += int'(pwm_hi_o);
      h2 += int'(pwm_lo_o);
    end
  endtask

  // Returns at the first sample where pwm_hi_o rose.
  task automatic wait_rise_hi();
    logic prev;
    @(negedge clk);
    prev = pwm_hi_o;
    for (int k = 0; k < 4 * PER; k++) begin
      @(negedge clk);
      if (!prev && pwm_hi_o) return;
      prev = pwm_hi_o;
    end
    check("R7 rise seen", 0, 1);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int h1, h2, per_len;
    logic prev;

    // R1: reset state with a full-scale setpoint waiting
    setpoint = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R1 hi in reset", int'(pwm_hi_o), 0);
    check("R1 lo in reset", int'(pwm_lo_o), 0);
    rst_n = 1'b1;
    count_hi(PER - 8, h1, h2);
    check("R1 hi first period", h1, 0);
    check("R1 lo first period", h2, 0);
    repeat (20) @(negedge clk);
    count_hi(PER, h1, h2);
    check("R5 hi duty 255", h1, 255 * D);
    check("R5 lo duty 255", h2, 255 * D);

    // R3 R4 R5: table walk, steady windows of one period
    for (int v = 0; v < NV; v++) begin
      setpoint = VEC[v];
      repeat (2 * PER) @(negedge clk);
      count_hi(PER, h1, h2);
      check($sformatf("R3 vec %0d", v), h1, int'(VEC[v][15:8]) * D);
      check($sformatf("R4 vec %0d", v), h2, int'(VEC[v][7:0]) * D);
    end

    // R6 R7: mid-period change ignored, phase from rising edge
    setpoint = 16'h8080;
    repeat (2 * PER) @(negedge clk);
    wait_rise_hi();
    h1 = int'(pwm_hi_o); h2 = int'(pwm_lo_o);
    for (int k = 1; k < PER; k++) begin
      if (k == 10) setpoint = 16'h4010;
      @(negedge clk);
      h1 += int'(pwm_hi_o);
      h2 += int'(pwm_lo_o);
    end
    check("R6 hi old duty kept", h1, 128 * D);
    check("R6 lo old duty kept", h2, 128 * D);
    count_hi(PER, h1, h2);
    check("R6 hi new duty", h1, 64 * D);
    check("R6 lo new duty", h2, 16 * D);

    // R2: rise-to-rise distance
    wait_rise_hi();
    per_len = 0;
    prev = 1'b1;
    for (int k = 0; k < 2 * PER; k++) begin
      @(negedge clk);
      per_len++;
      if (!prev && pwm_hi_o) break;
      prev = pwm_hi_o;
    end
    check("R2 period clocks", per_len, PER);

    // R8 R9: override at a known phase
    setpoint = 16'h0100;
    repeat (2 * PER) @(negedge clk);
    wait_rise_hi();
    force_high = 1'b1;
    count_hi(300, h1, h2);
    check("R8 hi held", h1, 300);
    check("R8 lo held", h2, 300);
    force_high = 1'b0;
    count_hi(PER, h1, h2);
    check("R9 hi until boundary", h1, (PER - 301) + D);
    check("R9 lo until boundary", h2, PER - 301);
    count_hi(PER, h1, h2);
    check("R9 hi after release", h1, D);
    check("R9 lo after release", h2, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule